// File: doc/BRIEF.md
# Delayed Register Update Queue

The block holds a small circular queue of pending register writes. Each accepted push names a destination register and a value. It also carries a delay in ticks, a width (a full 64-bit write or a low-half 32-bit write), and an optional single-bit mode with a bit position. Every cycle with `tick` high counts all live entries down by one. An entry whose count runs out is applied to an internal register file on that clock edge. In single-bit mode the entry sets the chosen bit when its value is nonzero and clears it otherwise. In word mode it overwrites the register, or only its low half for a 32-bit entry. The register file can be read at any time through a combinational read port. A registered mask reports which registers changed on the last edge.

Entries may expire in any order. The queue frees storage only from its oldest end. When the oldest entry expires, the output pointer moves past it and past every directly following entry that has already been applied. An applied entry that sits behind a still-waiting older entry keeps its slot until the older one goes.

A four-state occupancy machine (`Q_EMPTY`, `Q_PARTIAL`, `Q_FULL`, `Q_FAULT`) is updated every cycle from the next pending count:
- `Q_EMPTY`, `Q_PARTIAL` and `Q_FULL` move to whichever of the three matches the next pending count: zero, between one and the slot count minus one, or the slot count.
- Any of these states moves to `Q_FAULT` when the input and output pointers differ while the pending count is zero.
- `Q_FAULT` is absorbing until reset. In it, pushes are refused and ticks are ignored.

Top module: `dq_delayed_update`

## Requirements
- R1: After reset the pending count is 0, every register reads 0, and `push_overflow`, `upd_mask` and `fatal` are 0.
- R2: A push while fewer than SLOTS entries are pending is accepted. `push_accept` is high in that cycle, and the entry then counts toward `pending`.
- R3: A push while SLOTS entries are pending is refused. `push_accept` is low, `push_overflow` is high for exactly the next cycle, and no entry is added. Fullness is judged on the occupancy before any tick in the same cycle.
- R4: An entry pushed with delay D is applied on the edge of the D-th tick cycle after the push cycle. A delay of 0 acts as 1. A tick in the push cycle itself does not count, and cycles without a tick do not count.
- R5: A word-mode entry with the wide flag set replaces all 64 bits of the destination. With the wide flag clear it replaces bits 31:0 and keeps bits 63:32.
- R6: A single-bit entry changes only one bit of the destination. It sets the bit if any bit of the value is 1 and clears it otherwise. The bit index is the 6-bit position for a wide entry and the position's low 5 bits for a narrow entry.
- R7: When several entries expire on the same tick, they are applied from oldest to youngest, so for a shared destination the youngest entry's effect is the final one.
- R8: `pending` falls only on a tick where the oldest entry expires. It then falls by one for that entry and one for each directly following entry already applied. An entry expiring behind a waiting older entry leaves `pending` unchanged.
- R9: In the cycle after each edge, bit r of `upd_mask` is 1 exactly when register r was written by an expiring entry on that edge.
- R10: A push and a tick in the same cycle both take effect. The tick counts down existing entries, and the new entry is stored with its full delay.
- R11: `fatal` rises the cycle after the pointers disagree while `pending` is 0, stays high until reset, and stays low under any legal sequence of pushes and ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Request to enqueue an entry this cycle |
| push_dest | input | RIDX_W | Destination register index |
| push_wide | input | 1 | 1: 64-bit entry, 0: 32-bit entry |
| push_bit_en | input | 1 | 1: single-bit mode, 0: word mode |
| push_bit_pos | input | 6 | Bit index for single-bit mode |
| push_value | input | 64 | Data for word mode; zero/nonzero for single-bit mode |
| push_delay | input | DLY_W | Tick count until the entry is applied |
| tick | input | 1 | Count-down strobe for all live entries |
| push_accept | output | 1 | The push in this cycle is taken |
| push_overflow | output | 1 | A push was refused in the previous cycle |
| rd_idx | input | RIDX_W | Register file read index |
| rd_data | output | 64 | Register file content at `rd_idx` |
| upd_mask | output | NREGS | Registers written on the previous edge |
| pending | output | CNT_W | Slots held between the output and input pointers |
| fatal | output | 1 | Pointer inconsistency seen (sticky) |

## Verification
A single wide entry, then a narrow entry on the same register, separate the two widths: a wrong narrow write shows in the upper half. Bit set and clear with a position above 31 on a narrow entry tell the 5-bit from the 6-bit index. A short entry pushed behind a long one makes expiry out of order. The pending count then shows that the pointer moves only when the oldest entry goes, and that it jumps over the already-applied slot. Two entries on one register timed to expire together fix the order of application. Filling the queue, then pushing with and without a tick, exercises refusal and the overflow pulse. A long random run of pushes and ticks mixes all of these at once.

// File: rtl/dq_pkg.sv
package dq_pkg;

    localparam int DATA_W   = 64;
    localparam int HALF_W   = 32;
    localparam int BITPOS_W = 6;

    typedef enum logic [1:0] {
        Q_EMPTY   = 2'd0,
        Q_PARTIAL = 2'd1,
        Q_FULL    = 2'd2,
        Q_FAULT   = 2'd3
    } q_state_e;

    // New content of a register after one expiring entry is applied.
    function automatic logic [DATA_W-1:0] apply_update(
        input logic [DATA_W-1:0]   old_val,
        input logic                wide,
        input logic                bit_en,
        input logic [BITPOS_W-1:0] bit_pos,
        input logic [DATA_W-1:0]   value
    );
        logic [BITPOS_W-1:0] pos_eff;
        logic [DATA_W-1:0]   sel;
        logic [DATA_W-1:0]   res;
        pos_eff = wide ? bit_pos : {1'b0, bit_pos[BITPOS_W-2:0]};
        sel     = {{(DATA_W-1){1'b0}}, 1'b1} << pos_eff;
        if (bit_en) begin
            if (|value) res = old_val | sel;
            else        res = old_val & ~sel;
        end else if (wide) begin
            res = value;
        end else begin
            res = {old_val[DATA_W-1:HALF_W], value[HALF_W-1:0]};
        end
        return res;
    endfunction

endpackage

// File: rtl/dq_slot_store.sv
module dq_slot_store
    import dq_pkg::*;
#(
    parameter int SLOTS  = 8,
    parameter int RIDX_W = 3,
    parameter int DLY_W  = 4,
    localparam int PTR_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                wr_en,
    input  logic [PTR_W-1:0]    wr_ptr,
    input  logic [RIDX_W-1:0]   wr_dest,
    input  logic                wr_wide,
    input  logic                wr_bit_en,
    input  logic [BITPOS_W-1:0] wr_bit_pos,
    input  logic [DATA_W-1:0]   wr_value,
    input  logic [DLY_W-1:0]    wr_delay,
    output logic                live    [SLOTS],
    output logic                expire  [SLOTS],
    output logic [RIDX_W-1:0]   s_dest  [SLOTS],
    output logic                s_wide  [SLOTS],
    output logic                s_bit_en[SLOTS],
    output logic [BITPOS_W-1:0] s_pos   [SLOTS],
    output logic [DATA_W-1:0]   s_value [SLOTS]
);

    localparam logic [DLY_W-1:0] DLY_ONE = DLY_W'(1);

    logic [DLY_W-1:0] start_dly;
    assign start_dly = (wr_delay == '0) ? DLY_ONE : wr_delay;

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        logic [DLY_W-1:0] cnt;
        logic             load;

        assign load      = wr_en && (int'(wr_ptr) == i);
        assign expire[i] = tick && live[i] && (cnt == DLY_ONE);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                live[i]     <= 1'b0;
                cnt         <= '0;
                s_dest[i]   <= '0;
                s_wide[i]   <= 1'b0;
                s_bit_en[i] <= 1'b0;
                s_pos[i]    <= '0;
                s_value[i]  <= '0;
            end else if (load) begin
                live[i]     <= 1'b1;
                cnt         <= start_dly;
                s_dest[i]   <= wr_dest;
                s_wide[i]   <= wr_wide;
                s_bit_en[i] <= wr_bit_en;
                s_pos[i]    <= wr_bit_pos;
                s_value[i]  <= wr_value;
            end else if (tick && live[i]) begin
                if (cnt == DLY_ONE) live[i] <= 1'b0;
                else                cnt     <= cnt - DLY_ONE;
            end
        end
    end

endmodule

// File: rtl/dq_retire.sv
module dq_retire #(
    parameter int SLOTS = 8,
    localparam int PTR_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int CNT_W = $clog2(SLOTS + 1)
) (
    input  logic [PTR_W-1:0] out_ptr,
    input  logic [CNT_W-1:0] total,
    input  logic             live  [SLOTS],
    input  logic             expire[SLOTS],
    output logic [CNT_W-1:0] run
);

    // Length of the run of slots, oldest first, that are empty after this edge.
    always_comb begin
        int  cnt;
        int  idx;
        logic going;
        cnt   = 0;
        going = 1'b1;
        for (int k = 0; k < SLOTS; k++) begin
            idx = (int'(out_ptr) + k) % SLOTS;
            if (going && (k < int'(total)) && (!live[idx] || expire[idx]))
                cnt = cnt + 1;
            else
                going = 1'b0;
        end
        run = CNT_W'(cnt);
    end

endmodule

// File: rtl/dq_regfile.sv
module dq_regfile
    import dq_pkg::*;
#(
    parameter int SLOTS  = 8,
    parameter int NREGS  = 8,
    localparam int RIDX_W = (NREGS > 1) ? $clog2(NREGS) : 1,
    localparam int PTR_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PTR_W-1:0]    out_ptr,
    input  logic                expire  [SLOTS],
    input  logic [RIDX_W-1:0]   s_dest  [SLOTS],
    input  logic                s_wide  [SLOTS],
    input  logic                s_bit_en[SLOTS],
    input  logic [BITPOS_W-1:0] s_pos   [SLOTS],
    input  logic [DATA_W-1:0]   s_value [SLOTS],
    input  logic [RIDX_W-1:0]   rd_idx,
    output logic [DATA_W-1:0]   rd_data,
    output logic [NREGS-1:0]    upd_mask
);

    logic [DATA_W-1:0] regs    [NREGS];
    logic [DATA_W-1:0] regs_nxt[NREGS];
    logic [NREGS-1:0]  mask_nxt;

    // Oldest expiring entry first, so a younger one overrides it.
    always_comb begin
        int idx;
        int d;
        mask_nxt = '0;
        for (int r = 0; r < NREGS; r++) regs_nxt[r] = regs[r];
        for (int k = 0; k < SLOTS; k++) begin
            idx = (int'(out_ptr) + k) % SLOTS;
            d   = int'(s_dest[idx]);
            if (expire[idx] && (d < NREGS)) begin
                regs_nxt[d] = apply_update(regs_nxt[d], s_wide[idx], s_bit_en[idx],
                                           s_pos[idx], s_value[idx]);
                mask_nxt[d] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NREGS; r++) regs[r] <= '0;
            upd_mask <= '0;
        end else begin
            for (int r = 0; r < NREGS; r++) regs[r] <= regs_nxt[r];
            upd_mask <= mask_nxt;
        end
    end

    assign rd_data = (int'(rd_idx) < NREGS) ? regs[rd_idx] : '0;

endmodule

// File: rtl/dq_delayed_update.sv
module dq_delayed_update
    import dq_pkg::*;
#(
    parameter int SLOTS = 8,
    parameter int NREGS = 8,
    parameter int DLY_W = 4,
    localparam int RIDX_W = (NREGS > 1) ? $clog2(NREGS) : 1,
    localparam int PTR_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int CNT_W  = $clog2(SLOTS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                push_valid,
    input  logic [RIDX_W-1:0]   push_dest,
    input  logic                push_wide,
    input  logic                push_bit_en,
    input  logic [5:0]          push_bit_pos,
    input  logic [63:0]         push_value,
    input  logic [DLY_W-1:0]    push_delay,
    input  logic                tick,
    output logic                push_accept,
    output logic                push_overflow,
    input  logic [RIDX_W-1:0]   rd_idx,
    output logic [63:0]         rd_data,
    output logic [NREGS-1:0]    upd_mask,
    output logic [CNT_W-1:0]    pending,
    output logic                fatal
);

    q_state_e         state, state_nxt;
    logic [PTR_W-1:0] in_ptr, out_ptr;
    logic [CNT_W-1:0] total, total_nxt, run;
    logic             tick_eff;
    logic             mismatch;

    logic                live    [SLOTS];
    logic                expire  [SLOTS];
    logic [RIDX_W-1:0]   s_dest  [SLOTS];
    logic                s_wide  [SLOTS];
    logic                s_bit_en[SLOTS];
    logic [BITPOS_W-1:0] s_pos   [SLOTS];
    logic [DATA_W-1:0]   s_value [SLOTS];

    function automatic logic [PTR_W-1:0] ptr_add(input logic [PTR_W-1:0] p,
                                                 input int n);
        int s;
        s = int'(p) + n;
        if (s >= SLOTS) s = s - SLOTS;
        return PTR_W'(s);
    endfunction

    function automatic q_state_e level_of(input logic [CNT_W-1:0] n);
        if (n == '0)                 return Q_EMPTY;
        else if (int'(n) == SLOTS)   return Q_FULL;
        else                         return Q_PARTIAL;
    endfunction

    // Output process: handshake, gated tick and status come from the state.
    always_comb begin
        tick_eff    = 1'b0;
        push_accept = 1'b0;
        fatal       = 1'b0;
        unique case (state)
            Q_EMPTY, Q_PARTIAL: begin
                tick_eff    = tick;
                push_accept = push_valid;
            end
            Q_FULL: begin
                tick_eff    = tick;
            end
            Q_FAULT: begin
                fatal       = 1'b1;
            end
            default: ;
        endcase
    end

    assign mismatch  = (in_ptr != out_ptr) && (total == '0);
    assign total_nxt = CNT_W'(int'(total) - int'(run) + (push_accept ? 1 : 0));

    always_comb begin
        state_nxt = state;
        unique case (state)
            Q_EMPTY, Q_PARTIAL, Q_FULL:
                state_nxt = mismatch ? Q_FAULT : level_of(total_nxt);
            Q_FAULT:
                state_nxt = Q_FAULT;
            default:
                state_nxt = Q_FAULT;
        endcase
    end

    // State register process.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= Q_EMPTY;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_ptr        <= '0;
            out_ptr       <= '0;
            total         <= '0;
            push_overflow <= 1'b0;
        end else begin
            push_overflow <= push_valid && !push_accept;
            if (state != Q_FAULT) begin
                in_ptr  <= push_accept ? ptr_add(in_ptr, 1) : in_ptr;
                out_ptr <= ptr_add(out_ptr, int'(run));
                total   <= total_nxt;
            end
        end
    end

    assign pending = total;

    dq_slot_store #(
        .SLOTS (SLOTS),
        .RIDX_W(RIDX_W),
        .DLY_W (DLY_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_eff),
        .wr_en     (push_accept),
        .wr_ptr    (in_ptr),
        .wr_dest   (push_dest),
        .wr_wide   (push_wide),
        .wr_bit_en (push_bit_en),
        .wr_bit_pos(push_bit_pos),
        .wr_value  (push_value),
        .wr_delay  (push_delay),
        .live      (live),
        .expire    (expire),
        .s_dest    (s_dest),
        .s_wide    (s_wide),
        .s_bit_en  (s_bit_en),
        .s_pos     (s_pos),
        .s_value   (s_value)
    );

    dq_retire #(
        .SLOTS(SLOTS)
    ) u_retire (
        .out_ptr(out_ptr),
        .total  (total),
        .live   (live),
        .expire (expire),
        .run    (run)
    );

    dq_regfile #(
        .SLOTS(SLOTS),
        .NREGS(NREGS)
    ) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .out_ptr (out_ptr),
        .expire  (expire),
        .s_dest  (s_dest),
        .s_wide  (s_wide),
        .s_bit_en(s_bit_en),
        .s_pos   (s_pos),
        .s_value (s_value),
        .rd_idx  (rd_idx),
        .rd_data (rd_data),
        .upd_mask(upd_mask)
    );

endmodule

// File: rtl/dq_delayed_update_chk.sv
module dq_delayed_update_chk #(
    parameter int SLOTS = 8,
    parameter int NREGS = 8,
    localparam int CNT_W = $clog2(SLOTS + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             push_valid,
    input logic             push_accept,
    input logic             push_overflow,
    input logic             tick,
    input logic [NREGS-1:0] upd_mask,
    input logic [CNT_W-1:0] pending,
    input logic             fatal
);

    p_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && !push_accept) |=> push_overflow);

    p_overflow_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        push_overflow |-> $past(push_valid && !push_accept));

    p_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(pending) <= SLOTS);

    p_push_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (push_accept && !tick) |=> (int'(pending) == int'($past(pending)) + 1));

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!push_accept && !tick) |=> $stable(pending));

    p_mask_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> (upd_mask == '0));

    p_fatal_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fatal |=> fatal);

endmodule

bind dq_delayed_update dq_delayed_update_chk #(
    .SLOTS(SLOTS),
    .NREGS(NREGS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .push_valid   (push_valid),
    .push_accept  (push_accept),
    .push_overflow(push_overflow),
    .tick         (tick),
    .upd_mask     (upd_mask),
    .pending      (pending),
    .fatal        (fatal)
);

// File: tb/dq_delayed_update_bench.sv
module dq_delayed_update_bench;

    localparam int CLK_PERIOD = 20;
    localparam int SLOTS = 8;
    localparam int NREGS = 8;
    localparam int DLY_W = 4;
    localparam int RIDX_W = 3;
    localparam int CNT_W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic push_valid = 1'b0;
    logic [RIDX_W-1:0] push_dest = '0;
    logic push_wide = 1'b0;
    logic push_bit_en = 1'b0;
    logic [5:0] push_bit_pos = '0;
    logic [63:0] push_value = '0;
    logic [DLY_W-1:0] push_delay = '0;
    logic tick = 1'b0;
    logic push_accept, push_overflow, fatal;
    logic [RIDX_W-1:0] rd_idx = '0;
    logic [63:0] rd_data;
    logic [NREGS-1:0] upd_mask;
    logic [CNT_W-1:0] pending;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dq_delayed_update #(.SLOTS(SLOTS), .NREGS(NREGS), .DLY_W(DLY_W)) u_dq_delayed_update (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_dest(push_dest),
        .push_wide(push_wide), .push_bit_en(push_bit_en), .push_bit_pos(push_bit_pos),
        .push_value(push_value), .push_delay(push_delay), .tick(tick),
        .push_accept(push_accept), .push_overflow(push_overflow), .rd_idx(rd_idx),
        .rd_data(rd_data), .upd_mask(upd_mask), .pending(pending), .fatal(fatal)
    );

    // Behavioural reference: a list of entries in push order.
    int          q_dest[$];
    bit          q_wide[$];
    bit          q_ben[$];
    int          q_pos[$];
    logic [63:0] q_val[$];
    int          q_left[$];
    bit          q_done[$];
    logic [63:0] m_regs[NREGS];
    logic [NREGS-1:0] m_mask;
    bit          m_ovf;

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [63:0] ref_apply(input logic [63:0] old, input bit wide,
        input bit ben, input int pos, input logic [63:0] val);
        logic [63:0] r;
        int b;
        r = old;
        if (ben) begin
            b = wide ? pos : (pos % 32);
            r[b] = (val != 64'd0);
        end else if (wide) begin
            r = val;
        end else begin
            r[31:0] = val[31:0];
        end
        return r;
    endfunction

    task automatic model_step(input bit pv, input int dest, input bit wide, input bit ben,
                              input int pos, input logic [63:0] val, input int dly,
                              input bit tk);
        bit acc;
        acc = pv && (q_dest.size() < SLOTS);
        m_ovf = pv && !acc;
        m_mask = '0;
        if (tk) begin
            for (int k = 0; k < q_dest.size(); k++) begin
                if (!q_done[k]) begin
                    q_left[k] = q_left[k] - 1;
                    if (q_left[k] == 0) begin
                        m_regs[q_dest[k]] = ref_apply(m_regs[q_dest[k]], q_wide[k],
                                                      q_ben[k], q_pos[k], q_val[k]);
                        m_mask[q_dest[k]] = 1'b1;
                        q_done[k] = 1;
                    end
                end
            end
            while (q_dest.size() > 0 && q_done[0]) begin
                void'(q_dest.pop_front()); void'(q_wide.pop_front());
                void'(q_ben.pop_front());  void'(q_pos.pop_front());
                void'(q_val.pop_front());  void'(q_left.pop_front());
                void'(q_done.pop_front());
            end
        end
        if (acc) begin
            q_dest.push_back(dest); q_wide.push_back(wide); q_ben.push_back(ben);
            q_pos.push_back(pos);   q_val.push_back(val);
            q_left.push_back((dly == 0) ? 1 : dly);
            q_done.push_back(0);
        end
    endtask

    // Called at a falling edge: compare all outputs with the reference.
    task automatic compare_all(input string tag);
        check(int'(pending) == q_dest.size(), {tag, " R2 R8 pending"},
              64'(pending), 64'(q_dest.size()));
        check(upd_mask == m_mask, {tag, " R9 upd_mask"}, 64'(upd_mask), 64'(m_mask));
        check(push_overflow == m_ovf, {tag, " R3 overflow"}, 64'(push_overflow), 64'(m_ovf));
        check(fatal == 1'b0, {tag, " R11 fatal"}, 64'(fatal), 64'd0);
        for (int r = 0; r < NREGS; r++) begin
            rd_idx = RIDX_W'(r);
            #1;
            check(rd_data == m_regs[r], {tag, " R4 R5 R6 R7 register"}, rd_data, m_regs[r]);
        end
    endtask

    // Drive one cycle, check the handshake, advance model and compare after the edge.
    task automatic cyc(input string tag, input bit pv, input int dest, input bit wide,
                       input bit ben, input int pos, input logic [63:0] val,
                       input int dly, input bit tk);
        push_valid = pv; push_dest = RIDX_W'(dest); push_wide = wide;
        push_bit_en = ben; push_bit_pos = 6'(pos); push_value = val;
        push_delay = DLY_W'(dly); tick = tk;
        #1;
        check(push_accept == (pv && (q_dest.size() < SLOTS)), {tag, " R2 R3 R10 accept"},
              64'(push_accept), 64'(pv && (q_dest.size() < SLOTS)));
        model_step(pv, dest, wide, ben, pos, val, dly, tk);
        @(negedge clk);
        compare_all(tag);
    endtask

    task automatic idle(input string tag, input bit tk);
        cyc(tag, 0, 0, 0, 0, 0, 64'd0, 0, tk);
    endtask

    initial begin
        @(negedge clk);
        wait (finished == 0);
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int r = 0; r < NREGS; r++) m_regs[r] = '0;
        m_mask = '0; m_ovf = 0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        compare_all("R1 reset");

        // R5: wide word write, delay 2, ticks apart
        cyc("R5 wide", 1, 3, 1, 0, 0, 64'hA5A5_5A5A_1234_5678, 2, 0);
        idle("R4 no tick", 0);
        idle("R4 tick1", 1);
        idle("R4 tick2", 1);
        // R5: narrow write keeps upper half
        cyc("R5 narrow", 1, 3, 0, 0, 0, 64'hFFFF_FFFF_CAFE_F00D, 1, 0);
        idle("R5 narrow apply", 1);
        // R6: narrow bit position 37 acts on bit 5; wide on bit 37
        cyc("R6 set narrow", 1, 1, 0, 1, 37, 64'd9, 0, 0);
        cyc("R6 set wide", 1, 1, 1, 1, 37, 64'd1, 1, 1);
        idle("R6 apply", 1);
        cyc("R6 clear", 1, 3, 1, 1, 4, 64'd0, 1, 0);
        idle("R6 clear apply", 1);
        // R8: short entry behind a long one
        cyc("R8 long", 1, 2, 1, 0, 0, 64'h1111, 4, 0);
        cyc("R8 short", 1, 4, 1, 0, 0, 64'h2222, 1, 0);
        idle("R8 short expires", 1);
        idle("R8 wait", 1);
        idle("R8 wait2", 1);
        idle("R8 head expires", 1);
        // R7: two entries on one register expire together
        cyc("R7 older", 1, 5, 1, 0, 0, 64'hAAAA, 3, 0);
        cyc("R7 younger", 1, 5, 1, 0, 0, 64'hBBBB, 2, 1);
        idle("R7 t2", 1);
        idle("R7 same tick", 1);
        // R10: push with tick, delay 0
        cyc("R10 push+tick", 1, 6, 1, 0, 0, 64'h77, 0, 1);
        idle("R10 apply", 1);
        // R3: fill and overflow
        for (int i = 0; i < SLOTS; i++)
            cyc("R3 fill", 1, i, 1, 0, 0, 64'(i + 100), 15, 0);
        cyc("R3 push full", 1, 0, 1, 0, 0, 64'd1, 1, 0);
        cyc("R3 push full tick", 1, 0, 1, 0, 0, 64'd2, 1, 1);
        idle("R3 pulse end", 0);
        for (int i = 0; i < 16; i++) idle("R3 drain", 1);
        // Mixed random traffic
        for (int i = 0; i < 600; i++)
            cyc("R2 R4 R7 R8 random", ($urandom % 3) != 0, int'($urandom % NREGS),
                $urandom % 2, ($urandom % 3) == 0, int'($urandom % 64),
                {$urandom, $urandom} & (($urandom % 4 == 0) ? 64'd0 : {64{1'b1}}),
                int'($urandom % 6), ($urandom % 2) == 1);
        for (int i = 0; i < 20; i++) idle("R8 final drain", 1);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule